// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Lock

This block is a watchdog peripheral reached through an APB slave port. A down-counter of configurable width is loaded from a reload register. While counting is enabled, it decrements once on every clock cycle in which the tick-enable input is high. If software does not service the watchdog, the first expiry raises an interrupt and the counter starts again from the reload value. A second expiry, reached while that interrupt is still pending, latches a reset request and freezes the counter. Servicing consists of writing the clear register, which drops the pending interrupt and restarts the count.

Software can guard the configuration with a key-based lock. Board bring-up can take direct control of both outputs through an integration test mode. Twelve read-only identification words sit at the top of the 4 KB window. A build parameter selects a stricter variant. In that variant the control register can no longer be changed once counting is enabled, and the test registers are absent.

Top module: `wdt_apb_lock`

## Requirements
- R1: After synchronous reset, the reload register (0x00) and the current value (0x04) read 0xFFFFFFFF. Control (0x08), raw status (0x10) and lock (0xC00) read 0. Both outputs are low. The counter does not move on ticks.
- R2: A write to 0x00 sets the reload value and, in the same cycle, sets the current count to the written value.
- R3: Control bit 0 enables counting; other control bits except bit 1 read back as 0. A 0-to-1 change of bit 0 reloads the count from the reload register. While bit 0 is set, the count drops by one on each cycle with tick_en high, and does not change on other cycles. Clearing bit 0 stops the count.
- R4: A tick that arrives while the count is 0 and the raw flag (0x10 bit 0) is clear sets the raw flag and reloads the count.
- R5: A tick that arrives while the count is 0 and the raw flag is already set latches a reset request and freezes the count at 0. rst_req_o equals that request ANDed with control bit 1.
- R6: Any write to 0x0C, whatever the data, clears the raw flag and reloads the count. A read of 0x0C returns 0.
- R7: irq_o and the masked status (0x14 bit 0) equal the raw flag ANDed with control bit 0.
- R8: Writing 0x1ACCE551 to 0xC00 unlocks the block, and writing any other value locks it. While locked, writes to every other offset are ignored. 0xC00 reads 1 when locked.
- R9: When bit 0 of 0xF00 is set, irq_o follows bit 1 of 0xF04 and rst_req_o follows bit 0. 0xF00 reads back its bit 0, and 0xF04 reads 0.
- R10: The offsets 0xFD0 to 0xFFC, read upward, return 0x04,0x00,0x00,0x00,0x24,0xB8,0x1B,0x00,0x0D,0xF0,0x05,0xB1. Unmapped offsets read 0. Writes to 0x04 have no effect. pready is 1 and pslverr is 0.
- R11: With STICKY_CTRL=1, writes to control are ignored while control bit 0 is set. 0xF00 reads 0 and writes to 0xF00/0xF04 leave both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tick_en | input | 1 | Counter decrement enable |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
The checker watches several properties on every cycle. It checks that the count never exceeds the reload value and that the count holds while counting is off or halted. It checks that a reset request only rises after the interrupt flag was already pending. It also checks that unlocked reload and clear writes take effect one cycle later, and that locked writes leave the reload register untouched. Other behaviours are covered only by the directed scenarios: the exact tick on which each expiry lands, the gating of both outputs by the control bits, the lock key sequence, the identification values, the test-mode override, and the sticky-control variant compared against the default build.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned WIDX_W = 10;

    localparam logic [WIDX_W-1:0] IDX_LOAD   = 10'h000;
    localparam logic [WIDX_W-1:0] IDX_VALUE  = 10'h001;
    localparam logic [WIDX_W-1:0] IDX_CTRL   = 10'h002;
    localparam logic [WIDX_W-1:0] IDX_INTCLR = 10'h003;
    localparam logic [WIDX_W-1:0] IDX_RAW    = 10'h004;
    localparam logic [WIDX_W-1:0] IDX_MASKED = 10'h005;
    localparam logic [WIDX_W-1:0] IDX_LOCK   = 10'h300;
    localparam logic [WIDX_W-1:0] IDX_ITCR   = 10'h3C0;
    localparam logic [WIDX_W-1:0] IDX_ITOP   = 10'h3C1;
    localparam logic [WIDX_W-1:0] IDX_ID0    = 10'h3F4;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef struct packed {
        logic rst_en;
        logic cnt_en;
    } ctrl_t;

    typedef struct packed {
        logic irq;
        logic rst;
    } itop_t;

    typedef struct packed {
        logic              ld;
        logic              clr;
        logic              en_rise;
        logic [DATA_W-1:0] wdata;
    } cnt_cmd_t;

    function automatic logic [7:0] id_byte(input logic [3:0] sel);
        case (sel)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h24;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h1B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/wdt_regfile.sv
`timescale 1ns/1ps
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned STICKY_CTRL = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WIDX_W-1:0]    waddr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [CNT_W-1:0]     load_q,
    output ctrl_t                ctrl_q,
    output logic                 locked_q,
    output logic                 itcr_q,
    output itop_t                itop_q,
    output cnt_cmd_t             cmd
);

    localparam bit STICKY = (STICKY_CTRL != 0);

    logic wr_ok;
    logic ctrl_frozen;
    logic ctrl_take;

    assign wr_ok       = wr_en && !locked_q;
    assign ctrl_frozen = STICKY && ctrl_q.cnt_en;
    assign ctrl_take   = wr_ok && (waddr == IDX_CTRL) && !ctrl_frozen;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q   <= '1;
            ctrl_q   <= '0;
            locked_q <= 1'b0;
        end else begin
            if (wr_en && (waddr == IDX_LOCK)) begin
                locked_q <= (wdata != UNLOCK_KEY);
            end
            if (wr_ok && (waddr == IDX_LOAD)) begin
                load_q <= wdata[CNT_W-1:0];
            end
            if (ctrl_take) begin
                ctrl_q <= ctrl_t'(wdata[1:0]);
            end
        end
    end

    generate
        if (STICKY) begin : g_no_test
            assign itcr_q = 1'b0;
            assign itop_q = '0;
        end else begin : g_test
            always_ff @(posedge clk) begin
                if (rst) begin
                    itcr_q <= 1'b0;
                    itop_q <= '0;
                end else begin
                    if (wr_ok && (waddr == IDX_ITCR)) begin
                        itcr_q <= wdata[0];
                    end
                    if (wr_ok && (waddr == IDX_ITOP)) begin
                        itop_q <= itop_t'(wdata[1:0]);
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        cmd.ld      = wr_ok && (waddr == IDX_LOAD);
        cmd.clr     = wr_ok && (waddr == IDX_INTCLR);
        cmd.en_rise = ctrl_take && wdata[0] && !ctrl_q.cnt_en;
        cmd.wdata   = wdata;
    end

endmodule

// File: rtl/wdt_downcount.sv
`timescale 1ns/1ps
module wdt_downcount
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             run,
    input  logic [CNT_W-1:0] load_q,
    input  cnt_cmd_t         cmd,
    output logic [CNT_W-1:0] count_q,
    output logic             raw_q,
    output logic             rstreq_q
);

    logic active;
    logic at_zero;

    assign active  = run && !rstreq_q;
    assign at_zero = (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '1;
            raw_q    <= 1'b0;
            rstreq_q <= 1'b0;
        end else begin
            if (cmd.clr) begin
                raw_q <= 1'b0;
            end
            if (cmd.ld) begin
                count_q <= cmd.wdata[CNT_W-1:0];
            end else if (cmd.clr || cmd.en_rise) begin
                count_q <= load_q;
            end else if (active && tick_en) begin
                if (!at_zero) begin
                    count_q <= count_q - 1'b1;
                end else if (!raw_q) begin
                    raw_q   <= 1'b1;
                    count_q <= load_q;
                end else begin
                    rstreq_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdt_rdmux.sv
`timescale 1ns/1ps
module wdt_rdmux
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              psel,
    input  logic [WIDX_W-1:0] raddr,
    input  logic [CNT_W-1:0]  load_q,
    input  logic [CNT_W-1:0]  count_q,
    input  ctrl_t             ctrl_q,
    input  logic              raw_q,
    input  logic              locked_q,
    input  logic              itcr_q,
    output logic [DATA_W-1:0] prdata
);

    logic [DATA_W-1:0] rd_word;
    logic [3:0]        id_sel;

    assign id_sel = raddr[3:0] - 4'h4;

    always_comb begin
        rd_word = '0;
        case (raddr)
            IDX_LOAD:   rd_word = DATA_W'(load_q);
            IDX_VALUE:  rd_word = DATA_W'(count_q);
            IDX_CTRL:   rd_word = DATA_W'(ctrl_q);
            IDX_RAW:    rd_word = DATA_W'(raw_q);
            IDX_MASKED: rd_word = DATA_W'(raw_q && ctrl_q.cnt_en);
            IDX_LOCK:   rd_word = DATA_W'(locked_q);
            IDX_ITCR:   rd_word = DATA_W'(itcr_q);
            default: begin
                if (raddr >= IDX_ID0) begin
                    rd_word = DATA_W'(id_byte(id_sel));
                end
            end
        endcase
    end

    assign prdata = psel ? rd_word : '0;

endmodule

// File: rtl/wdt_outsel.sv
`timescale 1ns/1ps
module wdt_outsel
    import wdt_pkg::*;
(
    input  logic  itcr_q,
    input  itop_t itop_q,
    input  ctrl_t ctrl_q,
    input  logic  raw_q,
    input  logic  rstreq_q,
    output logic  irq_o,
    output logic  rst_req_o
);

    itop_t normal;

    always_comb begin
        normal.irq = raw_q && ctrl_q.cnt_en;
        normal.rst = rstreq_q && ctrl_q.rst_en;
        if (itcr_q) begin
            irq_o     = itop_q.irq;
            rst_req_o = itop_q.rst;
        end else begin
            irq_o     = normal.irq;
            rst_req_o = normal.rst;
        end
    end

endmodule

// File: rtl/wdt_apb_lock.sv
`timescale 1ns/1ps
module wdt_apb_lock
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned STICKY_CTRL = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    input  logic        tick_en,
    output logic        irq_o,
    output logic        rst_req_o
);

    logic              wr_en;
    logic [WIDX_W-1:0] widx;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  count_q;
    ctrl_t             ctrl_q;
    itop_t             itop_q;
    cnt_cmd_t          cmd;
    logic              locked_q;
    logic              itcr_q;
    logic              raw_q;
    logic              rstreq_q;
    logic              unused_lsb;

    assign wr_en      = psel && penable && pwrite;
    assign widx       = paddr[11:2];
    assign unused_lsb = ^paddr[1:0];
    assign pready     = 1'b1;
    assign pslverr    = 1'b0;

    wdt_regfile #(.CNT_W(CNT_W), .STICKY_CTRL(STICKY_CTRL)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(widx), .wdata(pwdata),
        .load_q(load_q), .ctrl_q(ctrl_q), .locked_q(locked_q),
        .itcr_q(itcr_q), .itop_q(itop_q), .cmd(cmd)
    );

    wdt_downcount #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .run(ctrl_q.cnt_en),
        .load_q(load_q), .cmd(cmd), .count_q(count_q), .raw_q(raw_q),
        .rstreq_q(rstreq_q)
    );

    wdt_rdmux #(.CNT_W(CNT_W)) rd_i (
        .psel(psel), .raddr(widx), .load_q(load_q), .count_q(count_q),
        .ctrl_q(ctrl_q), .raw_q(raw_q), .locked_q(locked_q),
        .itcr_q(itcr_q), .prdata(prdata)
    );

    wdt_outsel out_i (
        .itcr_q(itcr_q), .itop_q(itop_q), .ctrl_q(ctrl_q), .raw_q(raw_q),
        .rstreq_q(rstreq_q), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

endmodule

// File: rtl/wdt_apb_lock_chk.sv
`timescale 1ns/1ps
module wdt_apb_lock_chk
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WIDX_W-1:0] waddr,
    input logic [DATA_W-1:0] wdata,
    input logic              locked,
    input logic [CNT_W-1:0]  load_q,
    input logic [CNT_W-1:0]  count_q,
    input logic              raw_q,
    input logic              rstreq_q,
    input logic              run,
    input logic              itcr,
    input logic              irq_o
);

    a_r2_load_reload: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !locked && waddr == IDX_LOAD) |=> (count_q == $past(wdata[CNT_W-1:0])));

    a_r8_locked_load_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && locked && waddr == IDX_LOAD) |=> $stable(load_q));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(count_q));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= load_q);

    a_r5_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (rstreq_q && !wr_en) |=> $stable(count_q));

    a_r5_second_expiry: assert property (@(posedge clk) disable iff (rst)
        $rose(rstreq_q) |-> $past(raw_q));

    a_r6_clear_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !locked && waddr == IDX_INTCLR) |=> !raw_q);

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (!itcr && !raw_q) |-> !irq_o);

endmodule

bind wdt_apb_lock wdt_apb_lock_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(widx), .wdata(pwdata),
    .locked(locked_q), .load_q(load_q), .count_q(count_q), .raw_q(raw_q),
    .rstreq_q(rstreq_q), .run(ctrl_q.cnt_en), .itcr(itcr_q), .irq_o(irq_o)
);

// File: tb/wdt_apb_lock_tb_top.sv
`timescale 1ns/1ps
module wdt_apb_lock_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite, tick_en;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata_i, prdata_v;
    logic        pready_i, pslverr_i, pready_v, pslverr_v;
    logic        irq_i, rreq_i, irq_v, rreq_v;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          done    = 1'b0;

    logic [31:0] rd_i, rd_v;

    always #2.5 clk = ~clk;

    wdt_apb_lock dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_i), .pready(pready_i),
        .pslverr(pslverr_i), .tick_en(tick_en), .irq_o(irq_i), .rst_req_o(rreq_i)
    );

    wdt_apb_lock #(.STICKY_CTRL(1)) dut_v (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_v), .pready(pready_v),
        .pslverr(pslverr_v), .tick_en(tick_en), .irq_o(irq_v), .rst_req_o(rreq_v)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd_i = prdata_i;
        rd_v = prdata_v;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        apb_rd(12'h000); check("R1 load after reset", rd_i, 32'hFFFF_FFFF);
        apb_rd(12'h008); check("R1 ctrl after reset", rd_i, 32'h0);
        apb_rd(12'h010); check("R1 raw after reset", rd_i, 32'h0);
        apb_rd(12'hC00); check("R1 lock after reset", rd_i, 32'h0);
        check("R1 outputs after reset", {30'h0, irq_i, rreq_i}, 32'h0);
        tick(3);
        apb_rd(12'h004); check("R1 counter stopped", rd_i, 32'hFFFF_FFFF);
    endtask

    task automatic t_load_write();
        do_reset();
        apb_wr(12'h000, 32'd10);
        apb_rd(12'h004); check("R2 value follows load write", rd_i, 32'd10);
        apb_rd(12'h000); check("R2 load readback", rd_i, 32'd10);
    endtask

    task automatic t_counting();
        do_reset();
        apb_wr(12'h000, 32'd10);
        apb_wr(12'h008, 32'hFF);
        apb_rd(12'h008); check("R3 ctrl unused bits zero", rd_i, 32'h3);
        apb_wr(12'h008, 32'h1);
        tick(4);
        apb_rd(12'h004); check("R3 four ticks", rd_i, 32'd6);
        repeat (5) @(negedge clk);
        apb_rd(12'h004); check("R3 no tick no change", rd_i, 32'd6);
        apb_wr(12'h008, 32'h0);
        tick(2);
        apb_rd(12'h004); check("R3 stopped count holds", rd_i, 32'd6);
        apb_wr(12'h008, 32'h1);
        apb_rd(12'h004); check("R3 enable rise reloads", rd_i, 32'd10);
    endtask

    task automatic t_expiry();
        do_reset();
        apb_wr(12'h000, 32'd3);
        apb_wr(12'h008, 32'h1);
        tick(3);
        apb_rd(12'h004); check("R4 count reaches zero", rd_i, 32'd0);
        check("R4 no irq before expiry", {31'h0, irq_i}, 32'h0);
        tick(1);
        apb_rd(12'h010); check("R4 raw set on expiry", rd_i, 32'h1);
        apb_rd(12'h004); check("R4 reload on expiry", rd_i, 32'd3);
        check("R7 irq high", {31'h0, irq_i}, 32'h1);
        apb_rd(12'h014); check("R7 masked high", rd_i, 32'h1);
        apb_wr(12'h008, 32'h0);
        check("R7 irq gated off", {31'h0, irq_i}, 32'h0);
        apb_rd(12'h014); check("R7 masked gated off", rd_i, 32'h0);
        apb_rd(12'h010); check("R7 raw still set", rd_i, 32'h1);
        apb_wr(12'h008, 32'h3);
        tick(4);
        check("R5 reset request", {31'h0, rreq_i}, 32'h1);
        apb_rd(12'h004); check("R5 count frozen at zero", rd_i, 32'd0);
        tick(2);
        apb_rd(12'h004); check("R5 halted after ticks", rd_i, 32'd0);
        apb_wr(12'h008, 32'h1);
        check("R5 reset gated by bit1", {31'h0, rreq_i}, 32'h0);
    endtask

    task automatic t_clear();
        do_reset();
        apb_wr(12'h000, 32'd2);
        apb_wr(12'h008, 32'h1);
        tick(3);
        check("R6 irq before clear", {31'h0, irq_i}, 32'h1);
        tick(1);
        apb_wr(12'h00C, 32'hDEAD);
        apb_rd(12'h010); check("R6 raw cleared", rd_i, 32'h0);
        apb_rd(12'h004); check("R6 count reloaded", rd_i, 32'd2);
        check("R6 irq cleared", {31'h0, irq_i}, 32'h0);
        apb_rd(12'h00C); check("R6 clear reads zero", rd_i, 32'h0);
    endtask

    task automatic t_lock();
        do_reset();
        apb_wr(12'hC00, 32'h1234_5678);
        apb_rd(12'hC00); check("R8 locked reads one", rd_i, 32'h1);
        apb_wr(12'h000, 32'd5);
        apb_rd(12'h000); check("R8 locked load ignored", rd_i, 32'hFFFF_FFFF);
        apb_wr(12'h008, 32'h1);
        apb_rd(12'h008); check("R8 locked ctrl ignored", rd_i, 32'h0);
        apb_wr(12'hC00, 32'h1ACC_E551);
        apb_rd(12'hC00); check("R8 unlocked reads zero", rd_i, 32'h0);
        apb_wr(12'h000, 32'd5);
        apb_rd(12'h000); check("R8 unlocked load taken", rd_i, 32'd5);
    endtask

    task automatic t_test_mode();
        do_reset();
        apb_wr(12'hF00, 32'h1);
        apb_wr(12'hF04, 32'h2);
        check("R9 irq from test bit1", {30'h0, irq_i, rreq_i}, 32'h2);
        apb_wr(12'hF04, 32'h1);
        check("R9 reset from test bit0", {30'h0, irq_i, rreq_i}, 32'h1);
        apb_rd(12'hF00); check("R9 test ctrl readback", rd_i, 32'h1);
        apb_rd(12'hF04); check("R9 test out reads zero", rd_i, 32'h0);
        apb_wr(12'hF00, 32'h0);
        check("R9 normal outputs back", {30'h0, irq_i, rreq_i}, 32'h0);
    endtask

    task automatic t_ids();
        logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h24, 8'hB8,
                                    8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        do_reset();
        for (int k = 0; k < 12; k++) begin
            apb_rd(12'hFD0 + 12'(4 * k));
            check($sformatf("R10 id word %0d", k), rd_i, {24'h0, exp_id[k]});
        end
        apb_rd(12'h020); check("R10 unmapped reads zero", rd_i, 32'h0);
        apb_wr(12'h004, 32'd7);
        apb_rd(12'h004); check("R10 value write ignored", rd_i, 32'hFFFF_FFFF);
        check("R10 pready/pslverr", {30'h0, pready_i, pslverr_i}, 32'h2);
    endtask

    task automatic t_variant();
        do_reset();
        apb_wr(12'h008, 32'h1);
        apb_wr(12'h008, 32'h0);
        apb_rd(12'h008);
        check("R11 sticky ctrl kept", rd_v, 32'h1);
        check("R11 default ctrl cleared", rd_i, 32'h0);
        apb_wr(12'hF00, 32'h1);
        apb_wr(12'hF04, 32'h3);
        apb_rd(12'hF00);
        check("R11 variant test ctrl reads zero", rd_v, 32'h0);
        check("R11 variant outputs unchanged", {30'h0, irq_v, rreq_v}, 32'h0);
        check("R11 default test override", {30'h0, irq_i, rreq_i}, 32'h3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; tick_en = 1'b0;
        t_reset_state();
        t_load_write();
        t_counting();
        t_expiry();
        t_clear();
        t_lock();
        t_test_mode();
        t_ids();
        t_variant();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule